// File: doc/BRIEF.md
# Variable-Group Carry Bypass Adder

This block adds two unsigned operands and a carry-in in a single combinational evaluation. It returns the sum and the carry-out. The operand is split into groups of neighbouring bits. Inside a group, the carry ripples from bit to bit.

Each group also forms a group propagate signal. This signal is the AND of the exclusive-OR propagate terms of every bit in the group. When it is set, a 2:1 selector at the group output forwards the group's incoming carry unchanged. When it is clear, the selector takes the carry rippled out of the group's top bit. The carry-out of the whole adder is the output of the top group's selector.

The groups are given by a parameter that packs one size per group into a byte field, with group 0 in the lowest byte. The default is a 32-bit adder split as 1,3,5,7,7,5,3,1. Short groups at both ends and long groups in the middle shorten the worst path through the bypass chain. A uniform split, such as four groups of four bits over 16 bits, uses the same module. If the group sizes do not add up to the adder width, elaboration reports an error.

Top module: `skip_adder_top`

## Requirements
- R1: For any operands and carry-in, {carry_out, sum_out} equals op_a + op_b + carry_in, computed at full width plus one bit.
- R2: When every bit propagates (op_b = ~op_a), the result is sum all ones and carry-out 0 for carry-in 0. For carry-in 1, the result is sum 0 and carry-out 1, with the carry crossing every group through the bypass selectors.
- R3: With both operands zero, carry-in 0 gives sum 0 and carry-out 0, and carry-in 1 gives sum 1 and carry-out 0.
- R4: With both operands all ones, carry-in 0 gives sum all ones except bit 0 clear, with carry-out 1. Carry-in 1 gives sum all ones with carry-out 1.
- R5: A carry generated in the top bit of one group crosses the following fully propagating group and arrives at the first bit of the group after it.
- R6: Propagate is the exclusive-OR of the operand bits, so a bit where both operands are 1 generates a carry and does not bypass it. For example, 0x80000000 + 0x80000000 gives sum 0 and carry-out 1.
- R7: The same module, built as 16 bits in four 4-bit groups, satisfies R1 to R5 for 16-bit operands.
- R8: The carry leaving each group through its bypass selector always equals the carry rippled out of that group's top bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top group's bypass selector |

## Verification
The bench builds two instances of the adder. The first uses the default 32-bit 1,3,5,7,7,5,3,1 split, which exercises groups of a single bit at both ends and uneven group boundaries in the middle. The second is 16 bits wide with four 4-bit groups, which covers the uniform split through the same generate path. Directed carries placed on group boundaries in both instances force the bypass selectors to carry a real carry across a whole group.

// File: rtl/skip_adder_pkg.sv
package skip_adder_pkg;

    // Largest number of groups a partition vector may describe
    localparam int unsigned MAX_GRP = 32;
    localparam int unsigned FLD_W   = 8;

    typedef logic [MAX_GRP*FLD_W-1:0] part_vec_t;

    // Per-bit propagate/generate pair
    typedef struct packed {
        logic prop;
        logic gen;
    } pg_t;

    // Size of group idx from a packed partition
    function automatic int unsigned grp_len(input part_vec_t parts, input int unsigned idx);
        return int'(parts[idx*FLD_W +: FLD_W]);
    endfunction

    // Lowest bit index of group idx
    function automatic int unsigned grp_base(input part_vec_t parts, input int unsigned idx);
        int unsigned acc;
        acc = 0;
        for (int unsigned k = 0; k < idx; k++) begin
            acc += grp_len(parts, k);
        end
        return acc;
    endfunction

    // Total width covered by the first n groups
    function automatic int unsigned part_total(input part_vec_t parts, input int unsigned n);
        return grp_base(parts, n);
    endfunction

endpackage

// File: rtl/skip_bit_cell.sv
module skip_bit_cell
    import skip_adder_pkg::*;
(
    input  logic a_bit,
    input  logic b_bit,
    input  logic c_in,
    output pg_t  pg,
    output logic c_out,
    output logic s_bit
);

    always_comb begin
        pg.prop = a_bit ^ b_bit;
        pg.gen  = a_bit & b_bit;
        c_out   = pg.gen | (pg.prop & c_in);
        s_bit   = pg.prop ^ c_in;
    end

    // R6: a bit never both propagates and generates
    always_comb begin
        pg_exclusive_chk: assert (!(pg.prop && pg.gen))
            else $error("R6 bit propagates and generates at once");
    end

endmodule

// File: rtl/skip_group.sv
module skip_group
    import skip_adder_pkg::*;
#(
    parameter int unsigned GW = 4
) (
    input  logic [GW-1:0] a_grp,
    input  logic [GW-1:0] b_grp,
    input  logic          c_grp_in,
    output logic [GW-1:0] s_grp,
    output logic          c_grp_out
);

    logic [GW:0]   rip;
    pg_t  [GW-1:0] pgv;
    logic [GW-1:0] pv;
    logic          grp_prop;

    assign rip[0] = c_grp_in;

    for (genvar bi = 0; bi < GW; bi++) begin : g_bit
        skip_bit_cell u_cell (
            .a_bit (a_grp[bi]),
            .b_bit (b_grp[bi]),
            .c_in  (rip[bi]),
            .pg    (pgv[bi]),
            .c_out (rip[bi+1]),
            .s_bit (s_grp[bi])
        );
        assign pv[bi] = pgv[bi].prop;
    end

    assign grp_prop  = &pv;
    assign c_grp_out = grp_prop ? c_grp_in : rip[GW];

    // R8
    always_comb begin
        bypass_match_chk: assert (c_grp_out == rip[GW])
            else $error("R8 bypass carry %b differs from rippled %b", c_grp_out, rip[GW]);
    end

    // R2
    always_comb begin
        prop_no_gen_chk: assert (!grp_prop || (rip[GW] == c_grp_in))
            else $error("R2 fully propagating group altered its carry");
    end

endmodule

// File: rtl/skip_adder_top.sv
module skip_adder_top
    import skip_adder_pkg::*;
#(
    parameter int unsigned WIDTH     = 32,
    parameter int unsigned NGRP      = 8,
    parameter logic [NGRP*8-1:0] GRP_SIZES =
        {8'd1, 8'd3, 8'd5, 8'd7, 8'd7, 8'd5, 8'd3, 8'd1}
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    localparam part_vec_t PARTS   = part_vec_t'(GRP_SIZES);
    localparam int unsigned COVER = part_total(PARTS, NGRP);

    if (COVER != WIDTH) begin : g_bad_part
        $error("group sizes cover %0d bits, adder is %0d bits", COVER, WIDTH);
    end

    logic [NGRP:0] gc;
    assign gc[0] = carry_in;

    for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
        localparam int unsigned LO = grp_base(PARTS, gi);
        localparam int unsigned GL = grp_len(PARTS, gi);
        skip_group #(.GW(GL)) u_grp (
            .a_grp     (op_a[LO +: GL]),
            .b_grp     (op_b[LO +: GL]),
            .c_grp_in  (gc[gi]),
            .s_grp     (sum_out[LO +: GL]),
            .c_grp_out (gc[gi+1])
        );
    end

    assign carry_out = gc[NGRP];

    // R1
    always_comb begin
        total_sum_chk: assert ({carry_out, sum_out} ==
                               ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
            else $error("R1 adder result disagrees with arithmetic sum");
    end

    // R3
    always_comb begin
        zero_in_chk: assert (!((op_a == '0) && (op_b == '0)) ||
                             (!carry_out && (sum_out == {{(WIDTH-1){1'b0}}, carry_in})))
            else $error("R3 zero operands gave nonzero result");
    end

endmodule

// File: tb/test_skip_adder_top.sv
module test_skip_adder_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [31:0] a32, b32, s32;
    logic        c32, co32;
    logic [15:0] a16, b16, s16;
    logic        c16, co16;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    skip_adder_top i_skip_adder_top (
        .op_a(a32), .op_b(b32), .carry_in(c32),
        .sum_out(s32), .carry_out(co32)
    );

    skip_adder_top #(.WIDTH(16), .NGRP(4), .GRP_SIZES({8'd4, 8'd4, 8'd4, 8'd4})) i_uni (
        .op_a(a16), .op_b(b16), .carry_in(c16),
        .sum_out(s16), .carry_out(co16)
    );

    task automatic run32(input string tag, input logic [31:0] a, input logic [31:0] b,
                         input logic c, input logic [32:0] exp);
        @(posedge clk);
        a32 = a; b32 = b; c32 = c;
        @(negedge clk);
        n_chk++;
        if ({co32, s32} !== exp) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h c=%b actual=%h expected=%h", tag, a, b, c, {co32, s32}, exp);
        end
    endtask

    task automatic run16(input string tag, input logic [15:0] a, input logic [15:0] b,
                         input logic c, input logic [16:0] exp);
        @(posedge clk);
        a16 = a; b16 = b; c16 = c;
        @(negedge clk);
        n_chk++;
        if ({co16, s16} !== exp) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h c=%b actual=%h expected=%h", tag, a, b, c, {co16, s16}, exp);
        end
    endtask

    // R1: random operands against arithmetic
    task automatic t_random32();
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            logic c;
            a = $urandom; b = $urandom; c = 1'($urandom);
            run32("R1 random", a, b, c, {1'b0, a} + {1'b0, b} + {32'd0, c});
        end
    endtask

    // R2: every bit propagating
    task automatic t_allprop32();
        run32("R2 prop cin0", 32'h1234_5678, ~32'h1234_5678, 1'b0, {1'b0, 32'hFFFF_FFFF});
        run32("R2 prop cin1", 32'h1234_5678, ~32'h1234_5678, 1'b1, {1'b1, 32'h0});
        run32("R2 prop cin1 b", 32'h0, 32'hFFFF_FFFF, 1'b1, {1'b1, 32'h0});
    endtask

    // R3: zero operands
    task automatic t_zero32();
        run32("R3 zero cin0", 32'h0, 32'h0, 1'b0, 33'h0);
        run32("R3 zero cin1", 32'h0, 32'h0, 1'b1, 33'h1);
    endtask

    // R4: all ones
    task automatic t_ones32();
        run32("R4 ones cin0", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, {1'b1, 32'hFFFF_FFFE});
        run32("R4 ones cin1", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, {1'b1, 32'hFFFF_FFFF});
    endtask

    // R5: carry born at a group top crosses the next, fully propagating group
    task automatic t_boundary32();
        // bit 8 generates (top of bits 4..8); bits 9..15 all propagate; lands at bit 16
        run32("R5 skip 9-15", 32'h0000_FE00 | 32'h100, 32'h0000_0100, 1'b0, {1'b0, 32'h0001_0000});
        // bit 0 generates; bits 1..3 propagate; lands at bit 4
        run32("R5 skip 1-3", 32'h0000_000F, 32'h0000_0001, 1'b0, {1'b0, 32'h0000_0010});
        // bit 30 generates; bit 31 propagates; carry-out set
        run32("R5 skip 31", 32'hC000_0000, 32'h4000_0000, 1'b0, {1'b1, 32'h0});
    endtask

    // R6: both-ones bit generates, never bypasses
    task automatic t_xor32();
        run32("R6 msb gen", 32'h8000_0000, 32'h8000_0000, 1'b0, {1'b1, 32'h0});
        run32("R6 mid gen", 32'h0000_0F00, 32'h0000_0F00, 1'b1, {1'b0, 32'h0000_1E01});
    endtask

    // R7: uniform 16-bit build
    task automatic t_uniform16();
        run16("R7 zero", 16'h0, 16'h0, 1'b1, 17'h1);
        run16("R7 prop", 16'hA5A5, 16'h5A5A, 1'b1, {1'b1, 16'h0});
        run16("R7 ones", 16'hFFFF, 16'hFFFF, 1'b0, {1'b1, 16'hFFFE});
        run16("R7 skip 4-7", 16'h00F8, 16'h0008, 1'b0, 17'h0100);
        for (int i = 0; i < 200; i++) begin
            logic [15:0] a, b;
            logic c;
            a = 16'($urandom); b = 16'($urandom); c = 1'($urandom);
            run16("R7 random", a, b, c, {1'b0, a} + {1'b0, b} + {16'd0, c});
        end
    endtask

    // R8: bypass carry matches ripple at every group edge, seen through the sum
    task automatic t_groupcarry32();
        for (int k = 0; k < 32; k++) begin
            logic [31:0] a;
            a = 32'hFFFF_FFFF >> k;
            run32("R8 carry walk", a, 32'h1, 1'b0, {1'b0, a} + 33'h1);
        end
    endtask

    initial begin
        a32 = '0; b32 = '0; c32 = 1'b0;
        a16 = '0; b16 = '0; c16 = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_zero32();
        t_allprop32();
        t_ones32();
        t_boundary32();
        t_xor32();
        t_groupcarry32();
        t_random32();
        t_uniform16();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule